// File: doc/BRIEF.md
# Transfer CRC-8 Engine

This block computes the 8-bit check value for a serial transfer. Every byte that crosses the link goes through the engine, including the command bytes that open the transfer. The engine then supplies the byte that is sent at the end. A transfer controller outside the block chooses which bytes are covered. That controller pulses a synchronous clear whenever a transfer starts or is aborted, and it feeds data in one of two ways: one bit per clock with a bit strobe, or a whole byte per clock with a byte strobe.

The remainder register uses the generator polynomial x^8 + x^4 + x^3 + x^2 + 1 (0x1D). It starts from all ones and takes data most significant bit first. The byte to transmit is the bitwise inverse of the running remainder. A receiver can feed the received data and then the received check byte. A single compare output then shows whether the remainder has reached the fixed residue that a correct transfer always leaves.

Top module: `crc8x_xfer_checker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rem_out` is 8'hFF and `tx_byte` is 8'h00.
- R2: A `clr` pulse loads 8'hFF into the remainder on the next clock edge. This holds even when `bit_vld` or `byte_vld` is high in the same cycle, and the data offered in that cycle is discarded.
- R3: In a cycle with `bit_vld` high (and neither `clr` nor `byte_vld` high), the feedback bit is f = rem[7] XOR `bit_in`. The next remainder is {rem[6:0],0}, XORed with 8'h1D when f is 1.
- R4: In a cycle with `byte_vld` high (and `clr` low), the next remainder equals the result of eight R3 steps. These steps apply `byte_in[7]` first and `byte_in[0]` last, and all of them complete in one clock.
- R5: In a cycle with `clr`, `bit_vld` and `byte_vld` all low, the remainder holds its value whatever `bit_in` and `byte_in` carry.
- R6: `tx_byte` is the bitwise inverse of `rem_out` in every cycle.
- R7: After a clear and the four bytes 00h, 00h, 00h, 00h (fed either bytewise or as 32 zero bits), `tx_byte` is 8'h59.
- R8: When `byte_vld` and `bit_vld` are high in the same cycle without `clr`, only the byte is applied and the bit is discarded.
- R9: `rx_ok` is high exactly when the remainder equals the residue. The residue is the value that any byte sequence followed by its own `tx_byte` leaves behind: the R4 result of byte FFh applied to a zero remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear at transfer start or abort |
| bit_vld | input | 1 | Strobe: apply `bit_in` this cycle |
| bit_in | input | 1 | Serial data bit |
| byte_vld | input | 1 | Strobe: apply `byte_in` this cycle |
| byte_in | input | 8 | Parallel data byte, MSB applied first |
| rem_out | output | 8 | Running remainder |
| tx_byte | output | 8 | Inverted remainder, the check byte to send |
| rx_ok | output | 1 | Remainder equals the good-transfer residue |

## Verification
Every state error lives in the remainder register. Because `rem_out` exposes that register directly, a wrong feedback tap, a wrong bit order or a wrong preset shows up on the port one clock after the strobe that caused it. A wrong tap shows only when the feedback bit is 1. For that reason every byte value is swept in both bit and byte mode from the preset, and byte pairs are also swept, so each tap and each bit position is driven with feedback set. A fault in the arbitration between clear, byte and bit strobes shows up in the cycle after the strobes collide. A fault in the residue constant shows on `rx_ok` right after a check byte is fed back.

// File: rtl/crc8x_pkg.sv
package crc8x_pkg;

    localparam int unsigned CRC_W = 8;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_BIT   = 2'd2,
        UPD_BYTE  = 2'd3
    } upd_e;

    typedef struct packed {
        crc_t rem;
        crc_t tx;
        logic rx_ok;
    } crc_view_t;

    // One MSB-first division step of a single-register CRC.
    function automatic crc_t crc_bit_step(crc_t r, logic b, crc_t poly);
        logic fb;
        fb = r[CRC_W-1] ^ b;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

    // CRC_W bit steps, MSB of d first.
    function automatic crc_t crc_word_step(crc_t r, crc_t d, crc_t poly);
        crc_t acc;
        acc = r;
        for (int i = CRC_W - 1; i >= 0; i--) begin
            acc = crc_bit_step(acc, d[i], poly);
        end
        return acc;
    endfunction

    // Remainder left after a message followed by its own inverted check word.
    function automatic crc_t crc_residue(crc_t xorout, crc_t poly);
        return crc_word_step('0, xorout, poly);
    endfunction

endpackage

// File: rtl/crc8x_ctrl.sv
module crc8x_ctrl
    import crc8x_pkg::*;
(
    input  logic clr,
    input  logic bit_vld,
    input  logic byte_vld,
    output upd_e upd
);
    // Priority: clear, then byte, then bit.
    always_comb begin
        if (clr)           upd = UPD_CLEAR;
        else if (byte_vld) upd = UPD_BYTE;
        else if (bit_vld)  upd = UPD_BIT;
        else               upd = UPD_HOLD;
    end
endmodule

// File: rtl/crc8x_bit_stage.sv
module crc8x_bit_stage
    import crc8x_pkg::*;
#(
    parameter crc_t POLY = 8'h1D
) (
    input  crc_t rem_in,
    input  logic din,
    output crc_t rem_nx
);
    assign rem_nx = crc_bit_step(rem_in, din, POLY);
endmodule

// File: rtl/crc8x_next.sv
module crc8x_next
    import crc8x_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter crc_t        POLY   = 8'h1D,
    parameter crc_t        INIT   = 8'hFF
) (
    input  upd_e              upd,
    input  crc_t              rem_q,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] byte_in,
    output crc_t              rem_d
);
    crc_t chain [0:DATA_W];
    crc_t bit_nx;

    assign chain[0] = rem_q;

    // Unrolled byte path: stage i consumes byte_in[DATA_W-1-i].
    for (genvar i = 0; i < DATA_W; i++) begin : g_chain
        crc8x_bit_stage #(.POLY(POLY)) u_stage (
            .rem_in (chain[i]),
            .din    (byte_in[DATA_W-1-i]),
            .rem_nx (chain[i+1])
        );
    end

    crc8x_bit_stage #(.POLY(POLY)) u_serial (
        .rem_in (rem_q),
        .din    (bit_in),
        .rem_nx (bit_nx)
    );

    always_comb begin
        unique case (upd)
            UPD_CLEAR: rem_d = INIT;
            UPD_BYTE:  rem_d = chain[DATA_W];
            UPD_BIT:   rem_d = bit_nx;
            default:   rem_d = rem_q;
        endcase
    end
endmodule

// File: rtl/crc8x_xfer_checker.sv
module crc8x_xfer_checker
    import crc8x_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter crc_t        POLY   = 8'h1D,
    parameter crc_t        INIT   = 8'hFF,
    parameter crc_t        XOROUT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    output logic [CRC_W-1:0]  rem_out,
    output logic [CRC_W-1:0]  tx_byte,
    output logic              rx_ok
);
    localparam crc_t RESIDUE = crc_residue(XOROUT, POLY);

    upd_e      upd;
    crc_t      rem_q;
    crc_t      rem_d;
    crc_view_t view;

    crc8x_ctrl u_ctrl (
        .clr      (clr),
        .bit_vld  (bit_vld),
        .byte_vld (byte_vld),
        .upd      (upd)
    );

    crc8x_next #(
        .DATA_W (DATA_W),
        .POLY   (POLY),
        .INIT   (INIT)
    ) u_next (
        .upd     (upd),
        .rem_q   (rem_q),
        .bit_in  (bit_in),
        .byte_in (byte_in),
        .rem_d   (rem_d)
    );

    always_ff @(posedge clk) begin
        if (rst) rem_q <= INIT;
        else     rem_q <= rem_d;
    end

    always_comb begin
        view.rem   = rem_q;
        view.tx    = rem_q ^ XOROUT;
        view.rx_ok = (rem_q == RESIDUE);
    end

    assign rem_out = view.rem;
    assign tx_byte = view.tx;
    assign rx_ok   = view.rx_ok;
endmodule

// File: rtl/crc8x_sva.sv
module crc8x_sva
    import crc8x_pkg::*;
#(
    parameter crc_t POLY   = 8'h1D,
    parameter crc_t INIT   = 8'hFF,
    parameter crc_t XOROUT = 8'hFF
) (
    input logic       clk,
    input logic       rst,
    input logic       clr,
    input logic       bit_vld,
    input logic       bit_in,
    input logic       byte_vld,
    input logic [7:0] byte_in,
    input logic [7:0] rem_out,
    input logic [7:0] tx_byte,
    input logic       rx_ok
);
    p_reset_preset_r1: assert property (@(posedge clk) rst |=> rem_out == INIT);

    p_clear_wins_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> rem_out == INIT);

    p_bit_step_r3: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !byte_vld && !clr) |=>
            rem_out == crc_bit_step($past(rem_out), $past(bit_in), POLY));

    p_byte_step_r4: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !clr) |=>
            rem_out == crc_word_step($past(rem_out), $past(byte_in), POLY));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !bit_vld && !byte_vld) |=> $stable(rem_out));

    p_tx_invert_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_byte ^ rem_out) == XOROUT);

    p_residue_after_check_r9: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !clr && byte_in == tx_byte) |=> rx_ok);
endmodule

bind crc8x_xfer_checker crc8x_sva #(
    .POLY   (POLY),
    .INIT   (INIT),
    .XOROUT (XOROUT)
) u_sva (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .rem_out  (rem_out),
    .tx_byte  (tx_byte),
    .rx_ok    (rx_ok)
);

// File: tb/tb_crc8x_xfer_checker.sv
module tb_crc8x_xfer_checker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [7:0] rem_out;
    logic [7:0] tx_byte;
    logic       rx_ok;

    int n_total = 0;
    int n_fail  = 0;

    always #10ns clk = ~clk;

    crc8x_xfer_checker dut (
        .clk(clk), .rst(rst), .clr(clr),
        .bit_vld(bit_vld), .bit_in(bit_in),
        .byte_vld(byte_vld), .byte_in(byte_in),
        .rem_out(rem_out), .tx_byte(tx_byte), .rx_ok(rx_ok)
    );

    // Reference: polynomial long division with the full 9-bit divisor 0x11D.
    function automatic logic [7:0] ref_bit(logic [7:0] r, logic b);
        int x;
        x = ({24'd0, r} << 1) ^ (int'(b) << 8);
        if (x >= 256) x = x ^ 32'h11D;
        return x[7:0];
    endfunction

    function automatic logic [7:0] ref_byte(logic [7:0] r, logic [7:0] d);
        int x;
        x = int'(r ^ d);
        for (int k = 0; k < 8; k++) begin
            x = x << 1;
            if (x >= 256) x = x ^ 32'h11D;
        end
        return x[7:0];
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic put_byte(logic [7:0] b);
        @(negedge clk); byte_vld = 1'b1; byte_in = b;
        @(negedge clk); byte_vld = 1'b0; byte_in = ~b;
    endtask

    task automatic put_bit(logic b);
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
        @(negedge clk); bit_vld = 1'b0; bit_in = ~b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        logic [7:0] e;
        logic [7:0] residue;
        residue = ref_byte(8'h00, 8'hFF);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rem in reset", rem_out, 8'hFF);
        chk("R1 tx in reset", tx_byte, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rem after reset", rem_out, 8'hFF);
        chk("R6 tx after reset", tx_byte, 8'h00);
        chk("R9 rx_ok after reset", {7'd0, rx_ok}, {7'd0, 8'hFF == residue});

        // R4/R3/R6: every byte from the preset, bytewise and bitwise
        for (int b = 0; b < 256; b++) begin
            do_clr();
            put_byte(8'(b));
            e = ref_byte(8'hFF, 8'(b));
            chk("R4 byte sweep", rem_out, e);
            chk("R6 tx inverse", tx_byte, ~e);
            do_clr();
            e = 8'hFF;
            for (int k = 7; k >= 0; k--) begin
                put_bit(b[k]);
                e = ref_bit(e, b[k]);
                chk("R3 bit step", rem_out, e);
            end
            chk("R3 bits equal byte", rem_out, ref_byte(8'hFF, 8'(b)));
        end

        // R4: byte pairs
        for (int a = 0; a < 256; a++) begin
            do_clr();
            put_byte(8'(a));
            put_byte(8'(a * 7 + 3));
            chk("R4 byte pair", rem_out, ref_byte(ref_byte(8'hFF, 8'(a)), 8'(a * 7 + 3)));
        end

        // R7: known vector, bytewise and bitwise
        do_clr();
        for (int i = 0; i < 4; i++) put_byte(8'h00);
        chk("R7 four zero bytes", tx_byte, 8'h59);
        do_clr();
        for (int i = 0; i < 32; i++) put_bit(1'b0);
        chk("R7 32 zero bits", tx_byte, 8'h59);

        // R5: idle with toggling data inputs
        do_clr();
        put_byte(8'hA5);
        e = rem_out;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); byte_in = 8'(i * 37); bit_in = i[0];
        end
        chk("R5 hold on idle", rem_out, e);

        // R2: clear collides with strobes
        put_byte(8'h3C);
        @(negedge clk); clr = 1'b1; byte_vld = 1'b1; byte_in = 8'h77;
        @(negedge clk); clr = 1'b0; byte_vld = 1'b0;
        chk("R2 clear beats byte", rem_out, 8'hFF);
        put_byte(8'h3C);
        @(negedge clk); clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk); clr = 1'b0; bit_vld = 1'b0;
        chk("R2 clear beats bit", rem_out, 8'hFF);

        // R8: byte beats bit
        for (int b = 0; b < 16; b++) begin
            do_clr();
            @(negedge clk); byte_vld = 1'b1; byte_in = 8'(b * 17); bit_vld = 1'b1; bit_in = b[0];
            @(negedge clk); byte_vld = 1'b0; bit_vld = 1'b0;
            chk("R8 byte priority", rem_out, ref_byte(8'hFF, 8'(b * 17)));
        end

        // R9: message then its own check byte reaches residue
        for (int m = 0; m < 40; m++) begin
            do_clr();
            e = 8'hFF;
            for (int j = 0; j <= m % 5; j++) begin
                put_byte(8'(m * 13 + j * 101));
                e = ref_byte(e, 8'(m * 13 + j * 101));
            end
            chk("R9 rx_ok before check", {7'd0, rx_ok}, {7'd0, e == residue});
            put_byte(~e);
            chk("R9 rx_ok after check", {7'd0, rx_ok}, 8'h01);
            chk("R9 residue value", rem_out, residue);
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule